// File: doc/BRIEF.md
# Filtered Memory Bandwidth Monitor

This block sits beside a memory controller and measures traffic. It sees single-cycle request pulses and grant pulses. Each grant carries the number of the requesting port (0 to 31) and a 4-bit sub-device number. The block counts every request and every grant. It also counts the grants that pass each of four filter channels. Each channel filter is a pair of masks: a port bitmap and a sub-device bitmap. Port 23 is the port that aggregates small devices. To watch individual devices behind it, software sets mask bit 23 and selects devices in the sub-device bitmap. To accept every device of the chosen ports, software writes 0xFFFF to the sub-device bitmap.

Software reaches sixteen 32-bit registers on a word-indexed bus. A write takes effect at the clock edge. Reads are combinational from the index. A small sequencer has three states:

- `WS_OFF`: monitor disabled, nothing is counted.
- `WS_FREE`: counting runs with no time limit.
- `WS_TIMED`: counting runs in windows of a programmed length.

The sequencer moves as follows:

- It goes from `WS_OFF` to `WS_FREE` or `WS_TIMED` when the enable bit is set.
- It moves between `WS_FREE` and `WS_TIMED` when the timer bit changes, or when the window length changes between zero and nonzero.
- It returns to `WS_OFF` when the enable bit is cleared.

At the close of each window the running counts are copied into held copies and the running counts restart from zero. A sticky interrupt flag is set at the same time. Software reads the held copies and then writes the control word back to clear the flag.

Top module: `membw_monitor`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Register index map:
  - 0 is control.
  - Channel c uses a port mask at 2c+1 (32 bits) and a sub-device mask at 2c+2 (bits 15:0, upper bits read zero). Both read back what was written.
  - 9 is the request count and 10 the grant count.
  - 11 to 14 are the channel 0 to 3 grant counts.
  - 15 is the window length in clock cycles.
- R3: Control fields are bit 31 monitor enable, bit 30 interrupt flag, bit 20 timed-window mode and bits 3:0 channel enables. Other bits read zero. Clearing bit 31 puts the sequencer in `WS_OFF` two edges after the write.
- R4: A grant adds one to channel c only when all of these hold:
  - the monitor is on (not `WS_OFF`);
  - channel enable bit c is set;
  - the channel's port mask bit for the grant's port is set;
  - the channel's sub-device mask bit for the grant's sub-device is set.
- R5: A grant that passes several channels adds one to each of them in the same cycle.
- R6: While the monitor is on, every request pulse adds one to index 9 and every grant pulse adds one to index 10, whatever the filters hold.
- R7: While the monitor is off, request and grant pulses are ignored and all counts hold their values.
- R8: Writing zero to a count index clears that count, both its running and held copies. Writing a nonzero value to a count index is ignored. A channel whose two mask registers are zero counts nothing.
- R9: In `WS_TIMED` a window lasts exactly the programmed number of cycles. At its close:
  - the held copies take the running counts, including any event in the closing cycle;
  - the running counts restart at zero;
  - the flag is set.
- R10: `irq` equals the flag. Writing control with bit 30 set clears the flag unless a window closes in that cycle, in which case the flag stays set. Bits 31, 20 and 3:0 take the written value.
- R11: Counts saturate at all ones instead of wrapping.
- R12: With bit 20 clear, count indices read the running counts. With bit 20 set, they read the held copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| req_pulse | input | 1 | One request seen this cycle |
| gnt_pulse | input | 1 | One grant seen this cycle |
| gnt_port | input | 5 | Port number of the grant |
| gnt_sub | input | 4 | Sub-device number of the grant |
| irq | output | 1 | Window-closed interrupt flag level |

## Verification
The case of interest is a grant in the very cycle in which a window closes. The window counter advances while that grant is being added, so the grant must land in the closing window's held copy rather than in the next window. The bench waits for one window close, counts the programmed length in cycles from that close, and drives one grant in the last cycle of the next window. After that close, both the grant count and the channel count must read exactly one.

// File: rtl/membw_pkg.sv
package membw_pkg;

    localparam int NUM_CH = 4;

    localparam logic [3:0] IDX_CTRL  = 4'd0;
    localparam logic [3:0] IDX_REQ   = 4'd9;
    localparam logic [3:0] IDX_GNT   = 4'd10;
    localparam logic [3:0] IDX_CH0   = 4'd11;
    localparam logic [3:0] IDX_TIMER = 4'd15;

    localparam int BIT_EN    = 31;
    localparam int BIT_FLAG  = 30;
    localparam int BIT_TIMED = 20;

    typedef enum logic [1:0] {
        WS_OFF   = 2'd0,
        WS_FREE  = 2'd1,
        WS_TIMED = 2'd2
    } win_state_t;

endpackage

// File: rtl/membw_filter.sv
module membw_filter (
    input  logic [31:0] port_mask,
    input  logic [15:0] sub_mask,
    input  logic [4:0]  port_id,
    input  logic [3:0]  sub_id,
    output logic        hit
);
    // two-level match: the port bit selects, the device bit qualifies
    always_comb begin
        hit = port_mask[port_id] & sub_mask[sub_id];
    end
endmodule

// File: rtl/membw_counter.sv
module membw_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         clr,
    input  logic         close,
    output logic [W-1:0] live,
    output logic [W-1:0] held
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] bumped;

    always_comb begin
        bumped = (inc && live != TOP) ? live + W'(1) : live;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
            held <= '0;
        end else if (clr) begin
            live <= '0;
            held <= '0;
        end else if (close) begin
            held <= bumped;
            live <= '0;
        end else begin
            live <= bumped;
        end
    end

    // R11
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live == TOP && !clr && !close) |=> (live == TOP));

    // R8
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (live == '0 && held == '0));
endmodule

// File: rtl/membw_window.sv
module membw_window
    import membw_pkg::*;
#(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mon_en,
    input  logic          timed,
    input  logic [TW-1:0] win_len,
    output win_state_t    state,
    output logic          close,
    output logic          counting
);
    win_state_t    nxt;
    logic [TW-1:0] elapsed;

    always_comb begin
        if (!mon_en)
            nxt = WS_OFF;
        else if (timed && win_len != '0)
            nxt = WS_TIMED;
        else
            nxt = WS_FREE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= WS_OFF;
        else
            state <= nxt;
    end

    always_comb begin
        close    = 1'b0;
        counting = 1'b0;
        unique case (state)
            WS_OFF: begin
                close    = 1'b0;
                counting = 1'b0;
            end
            WS_FREE: begin
                close    = 1'b0;
                counting = 1'b1;
            end
            WS_TIMED: begin
                close    = (elapsed >= win_len - TW'(1));
                counting = 1'b1;
            end
            default: begin
                close    = 1'b0;
                counting = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            elapsed <= '0;
        else if (state != WS_TIMED || close)
            elapsed <= '0;
        else
            elapsed <= elapsed + TW'(1);
    end

    // R9
    close_timed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> (elapsed == '0));
endmodule

// File: rtl/membw_monitor.sv
module membw_monitor
    import membw_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int TMR_W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        req_pulse,
    input  logic        gnt_pulse,
    input  logic [4:0]  gnt_port,
    input  logic [3:0]  gnt_sub,
    output logic        irq
);
    logic              ctrl_en, ctrl_flag, ctrl_timed;
    logic [NUM_CH-1:0] ctrl_chen;
    logic [TMR_W-1:0]  win_len;
    logic [31:0]       pmask [NUM_CH];
    logic [15:0]       smask [NUM_CH];
    logic [CNT_W-1:0]  ch_live [NUM_CH];
    logic [CNT_W-1:0]  ch_held [NUM_CH];
    logic [CNT_W-1:0]  req_live, req_held, gnt_live, gnt_held;
    logic [NUM_CH-1:0] ch_hit;
    win_state_t        win_state;
    logic              win_close, counting;
    logic              wr_ctrl, wr_zero;

    assign wr_ctrl = reg_we && reg_addr == IDX_CTRL;
    assign wr_zero = reg_we && reg_wdata == 32'd0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en    <= 1'b0;
            ctrl_timed <= 1'b0;
            ctrl_chen  <= '0;
        end else if (wr_ctrl) begin
            ctrl_en    <= reg_wdata[BIT_EN];
            ctrl_timed <= reg_wdata[BIT_TIMED];
            ctrl_chen  <= reg_wdata[NUM_CH-1:0];
        end
    end

    // closing a window outranks a software clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_flag <= 1'b0;
        else if (win_close)
            ctrl_flag <= 1'b1;
        else if (wr_ctrl && reg_wdata[BIT_FLAG])
            ctrl_flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            win_len <= '0;
        else if (reg_we && reg_addr == IDX_TIMER)
            win_len <= reg_wdata[TMR_W-1:0];
    end

    membw_window #(.TW(TMR_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .mon_en   (ctrl_en),
        .timed    (ctrl_timed),
        .win_len  (win_len),
        .state    (win_state),
        .close    (win_close),
        .counting (counting)
    );

    membw_counter #(.W(CNT_W)) u_req (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (req_pulse && counting),
        .clr   (wr_zero && reg_addr == IDX_REQ),
        .close (win_close),
        .live  (req_live),
        .held  (req_held)
    );

    membw_counter #(.W(CNT_W)) u_gnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (gnt_pulse && counting),
        .clr   (wr_zero && reg_addr == IDX_GNT),
        .close (win_close),
        .live  (gnt_live),
        .held  (gnt_held)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [3:0] PM_IDX = 4'(2 * c + 1);
        localparam logic [3:0] SM_IDX = 4'(2 * c + 2);
        localparam logic [3:0] CT_IDX = IDX_CH0 + 4'(c);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pmask[c] <= '0;
                smask[c] <= '0;
            end else if (reg_we && reg_addr == PM_IDX) begin
                pmask[c] <= reg_wdata;
            end else if (reg_we && reg_addr == SM_IDX) begin
                smask[c] <= reg_wdata[15:0];
            end
        end

        membw_filter u_flt (
            .port_mask (pmask[c]),
            .sub_mask  (smask[c]),
            .port_id   (gnt_port),
            .sub_id    (gnt_sub),
            .hit       (ch_hit[c])
        );

        membw_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (gnt_pulse && counting && ctrl_chen[c] && ch_hit[c]),
            .clr   (wr_zero && reg_addr == CT_IDX),
            .close (win_close),
            .live  (ch_live[c]),
            .held  (ch_held[c])
        );
    end

    always_comb begin
        reg_rdata = 32'd0;
        if (reg_addr == IDX_CTRL) begin
            reg_rdata[BIT_EN]       = ctrl_en;
            reg_rdata[BIT_FLAG]     = ctrl_flag;
            reg_rdata[BIT_TIMED]    = ctrl_timed;
            reg_rdata[NUM_CH-1:0]   = ctrl_chen;
        end else if (reg_addr < IDX_REQ) begin
            if (reg_addr[0])
                reg_rdata = pmask[2'((reg_addr - 4'd1) >> 1)];
            else
                reg_rdata = {16'd0, smask[2'((reg_addr - 4'd1) >> 1)]};
        end else if (reg_addr == IDX_REQ) begin
            reg_rdata = 32'(ctrl_timed ? req_held : req_live);
        end else if (reg_addr == IDX_GNT) begin
            reg_rdata = 32'(ctrl_timed ? gnt_held : gnt_live);
        end else if (reg_addr == IDX_TIMER) begin
            reg_rdata = 32'(win_len);
        end else begin
            reg_rdata = 32'(ctrl_timed ? ch_held[2'(reg_addr - IDX_CH0)]
                                       : ch_live[2'(reg_addr - IDX_CH0)]);
        end
    end

    assign irq = ctrl_flag;

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_state == WS_OFF && !reg_we) |=> $stable(gnt_live));

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && reg_wdata[BIT_FLAG] && !win_close) |=> !irq);

    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_close |=> irq);

    // R9
    rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(win_close));

    // R3
    off_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !reg_wdata[BIT_EN]) |=> ##1 (win_state == WS_OFF));
endmodule

// File: tb/membw_monitor_bench.sv
`timescale 1ns/1ps
module membw_monitor_bench;

    typedef struct {
        logic        is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_pulse = 1'b0;
    logic        gnt_pulse = 1'b0;
    logic [4:0]  gnt_port = '0;
    logic [3:0]  gnt_sub = '0;
    logic        irq;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    item_t q[$];

    always #2 clk = ~clk;

    membw_monitor #(.CNT_W(8), .TMR_W(32)) u_membw_monitor (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .req_pulse (req_pulse),
        .gnt_pulse (gnt_pulse),
        .gnt_port  (gnt_port),
        .gnt_sub   (gnt_sub),
        .irq       (irq)
    );

    // monitor: compares pushed expectations at the falling edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            act = it.is_irq ? {31'd0, irq} : reg_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] idx, input logic [31:0] val);
        @(posedge clk);
        #1 reg_we = 1'b1; reg_addr = idx; reg_wdata = val;
        @(posedge clk);
        #1 reg_we = 1'b0;
    endtask

    task automatic chk(input logic [3:0] idx, input logic [31:0] val, input string tag);
        item_t it;
        @(posedge clk);
        #1 reg_addr = idx;
        it.is_irq = 1'b0; it.exp = val; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic val, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        it.is_irq = 1'b1; it.exp = {31'd0, val}; it.tag = tag;
        q.push_back(it);
        @(negedge clk);
    endtask

    task automatic grant(input logic [4:0] p, input logic [3:0] s);
        @(posedge clk);
        #1 gnt_pulse = 1'b1; gnt_port = p; gnt_sub = s;
        @(posedge clk);
        #1 gnt_pulse = 1'b0;
    endtask

    task automatic request();
        @(posedge clk);
        #1 req_pulse = 1'b1;
        @(posedge clk);
        #1 req_pulse = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        chk(4'd0, 32'h0, "R1 ctrl");
        chk(4'd9, 32'h0, "R1 req count");
        chk(4'd15, 32'h0, "R1 timer");
        chk_irq(1'b0, "R1 irq");

        // filters: ch0 port5 any dev, ch1 port23 dev3, ch2 ports 5|7, ch3 zeroed
        wr(4'd1, 32'h0000_0020); wr(4'd2, 32'h0000_FFFF);
        wr(4'd3, 32'h0080_0000); wr(4'd4, 32'h0000_0008);
        wr(4'd5, 32'h0000_00A0); wr(4'd6, 32'h0000_FFFF);
        wr(4'd7, 32'h0000_0020); wr(4'd8, 32'h0000_FFFF);
        wr(4'd7, 32'h0); wr(4'd8, 32'h0);
        chk(4'd5, 32'h0000_00A0, "R2 port mask readback");
        chk(4'd4, 32'h0000_0008, "R2 sub mask readback");
        wr(4'd6, 32'hFFFF_FFFF);
        chk(4'd6, 32'h0000_FFFF, "R2 sub mask upper bits zero");

        wr(4'd0, 32'hFFFF_FFFF);
        chk(4'd0, 32'hC010_000F & 32'hBFFF_FFFF, "R3 ctrl fields");
        wr(4'd0, 32'h8000_000F);
        chk(4'd0, 32'h8000_000F, "R3 ctrl free mode");

        for (int i = 0; i < 3; i++) grant(5'd5, 4'd0);
        grant(5'd23, 4'd3); grant(5'd23, 4'd3);
        grant(5'd23, 4'd4);
        grant(5'd7, 4'd9);
        for (int i = 0; i < 4; i++) request();
        // R6 R12 global counts read live in free mode
        chk(4'd9, 32'd4, "R6 req count");
        chk(4'd10, 32'd7, "R6 gnt count");
        // R4 port and device masks
        chk(4'd11, 32'd3, "R4 ch0 port5");
        chk(4'd12, 32'd2, "R4 ch1 device filter");
        // R5 port5 grants hit ch0 and ch2 together
        chk(4'd13, 32'd4, "R5 ch2 shared grants");
        // R8 zeroed filter counts nothing
        chk(4'd14, 32'd0, "R8 ch3 zero filter");

        // R4 channel enable gates
        wr(4'd0, 32'h8000_000B);
        grant(5'd5, 4'd1);
        chk(4'd11, 32'd4, "R4 ch0 enabled");
        chk(4'd13, 32'd4, "R4 ch2 disabled");

        // R8 zero write clears, nonzero ignored
        wr(4'd9, 32'h0);
        chk(4'd9, 32'd0, "R8 clear req");
        wr(4'd10, 32'd5);
        chk(4'd10, 32'd8, "R8 nonzero write ignored");

        // R7 disabled ignores events
        wr(4'd0, 32'h0);
        repeat (2) @(posedge clk);
        grant(5'd5, 4'd0);
        request();
        chk(4'd10, 32'd8, "R7 gnt held");
        chk(4'd11, 32'd4, "R7 ch0 held");
        chk(4'd9, 32'd0, "R7 req held");

        // R11 saturation at 8-bit top
        wr(4'd0, 32'h8000_0000);
        @(posedge clk);
        #1 req_pulse = 1'b1;
        repeat (300) @(posedge clk);
        #1 req_pulse = 1'b0;
        chk(4'd9, 32'd255, "R11 saturate");

        // R9 timed windows
        wr(4'd0, 32'h0);
        wr(4'd9, 32'h0); wr(4'd10, 32'h0); wr(4'd11, 32'h0);
        wr(4'd12, 32'h0); wr(4'd13, 32'h0);
        wr(4'd15, 32'd20);
        chk(4'd15, 32'd20, "R2 timer readback");
        wr(4'd0, 32'h8010_0001);
        for (int i = 0; i < 5; i++) grant(5'd5, 4'd2);
        chk(4'd10, 32'd0, "R12 held before close");
        begin
            int guard = 0;
            while (!irq && guard < 100) begin
                @(negedge clk);
                guard++;
            end
        end
        chk(4'd10, 32'd5, "R9 held gnt");
        chk(4'd11, 32'd5, "R9 held ch0");
        chk(4'd0, 32'hC010_0001, "R10 flag in ctrl");
        chk_irq(1'b1, "R10 irq level");
        wr(4'd0, 32'hC010_0001);
        chk_irq(1'b0, "R10 flag cleared");
        chk(4'd0, 32'h8010_0001, "R10 enable kept");

        // R9 grant in the closing cycle belongs to the closing window
        begin
            int guard = 0;
            while (!irq && guard < 100) begin
                @(negedge clk);
                guard++;
            end
        end
        repeat (19) @(posedge clk);
        #1 gnt_pulse = 1'b1; gnt_port = 5'd5; gnt_sub = 4'd0;
        @(posedge clk);
        #1 gnt_pulse = 1'b0;
        chk(4'd10, 32'd1, "R9 closing-cycle gnt");
        chk(4'd11, 32'd1, "R9 closing-cycle ch0");

        repeat (2) @(posedge clk);
        done = 1'b1;
        summary();
    end
endmodule